// File: doc/BRIEF.md
# Capture-Compare Timer with Period Clear

A 16-bit up-counter steps once per count-enable pulse (`tick`) while the timer is running. A compare register sets the counting period. When the count reaches the compare value, the next step returns it to zero and raises a one-clock match pulse. Two compare values have special meaning. Zero freezes the counter and holds the match output high. All-ones gives a free-running counter that reports each wrap on a separate overflow pulse.

A capture channel samples an external pin through a clock-domain synchroniser. The channel looks for edges only on count-enable pulses. On a selected edge it stores the current count, raises a capture pulse, and updates a flag. The flag tells software whether the interval since the previous capture crossed at least one period clear. Software programs the compare value and the edge selection through a single-cycle write port.

Top module: `cc_timer`

## Requirements
- R1: When `run` is high, each clock with `tick` high adds one to `count`. With `tick` low, `count` holds. With `run` low, `count` goes to 0 at the next clock.
- R2: Take a compare value other than 0000H and FFFFH. A tick that finds `count` equal to it loads 0 instead of adding one, and `match_irq` is high for that one following clock. For compare 0FFFH this gives the sequence 0FFEH, 0FFFH, 0000H.
- R3: With compare 0000H and `run` high, `count` stays 0 and `match_irq` stays high continuously.
- R4: With compare FFFFH the counter runs free. A tick at FFFFH wraps the count to 0 and raises `ovf_irq` for one clock. `match_irq` is never raised.
- R5: A write with `wr_sel`=0 loads `wr_data` as the compare value. A write with `wr_sel`=1 loads `wr_data[1:0]` as the edge selection: 00 none, 01 rising, 10 falling, 11 both. An edge that is not selected leaves `cap_irq` low and `cap_value` unchanged.
- R6: Take `tick` held high. After `cap_in` changes between clock edges, `cap_irq` goes high at the third rising clock edge. At that edge `cap_value` takes the count present in the cycle just before it. In general, an edge is seen at the first tick after two clock edges of synchronisation.
- R7: With selection 11, every transition of `cap_in` produces a capture.
- R8: At each capture, `cap_spanned` becomes 1 if a period clear (R2) happened since the previous capture or since reset. Otherwise it becomes 0. A clear on the same tick as a capture counts toward the next interval.
- R9: `match_irq` (outside the R3 case), `ovf_irq` and `cap_irq` are single-clock pulses.
- R10: A synchronous `rst` clears `count`, `cap_value`, `cap_spanned` and all pulses. It also sets the compare value to FFFFH and the edge selection to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the compare value, 1 selects the edge selection |
| wr_data | input | 16 | Write data |
| run | input | 1 | Count start; low holds the counter at 0 |
| tick | input | 1 | Count-enable pulse |
| cap_in | input | 1 | Asynchronous capture pin |
| count | output | 16 | Current counter value |
| match_irq | output | 1 | Period-clear interrupt |
| ovf_irq | output | 1 | Wrap interrupt |
| cap_irq | output | 1 | Capture interrupt |
| cap_value | output | 16 | Last captured count |
| cap_spanned | output | 1 | A clear happened inside the last capture interval |

## Verification
Suppose the counter's next-value choice goes wrong, for example by clearing one step late or treating FFFFH as a period. Then `count` and the pulse tallies differ from the computed values at the end of the very next period, within a few thousand clocks. A fault in the synchroniser depth or in the edge-detector memory shows up on the first capture as `cap_irq` moving by a clock, or as a wrong or missing `cap_value`. A stale interval record shows up as a wrong `cap_spanned` at the second capture after a reset.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int unsigned TMR_W = 16;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // true when the synchronised pin moved in a direction the selection accepts
  function automatic logic edge_hit(input logic [1:0] sel, input logic now, input logic prev);
    return (sel[0] && now && !prev) || (sel[1] && !now && prev);
  endfunction
endpackage

// File: rtl/cc_count_core.sv
module cc_count_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] count,
  output logic         match_irq,
  output logic         ovf_irq,
  output logic         clear_evt
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ALL1 = '1;

  // terminal values 0 and all-ones never act as a period
  function automatic logic period_hit(input logic [W-1:0] cnt, input logic [W-1:0] c);
    return (cnt == c) && (c != ZERO) && (c != ALL1);
  endfunction

  logic         step;
  logic         wrap_evt;
  logic         match_q;
  logic         ovf_q;
  logic         hold_zero;

  assign step      = tick && run;
  assign clear_evt = step && period_hit(count, cmp);
  assign wrap_evt  = step && (count == ALL1) && !clear_evt;
  assign hold_zero = !run || (cmp == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= ZERO;
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      match_q <= clear_evt;
      ovf_q   <= wrap_evt;
      if (hold_zero || clear_evt) count <= ZERO;
      else if (tick)              count <= count + 1'b1;
    end
  end

  assign match_irq = match_q || (run && (cmp == ZERO));
  assign ovf_irq   = ovf_q;

  a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> (count == ZERO) && match_irq);
  a_r3_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (run && cmp == ZERO) |=> (count == ZERO));
  a_r4_no_match_freerun: assert property (@(posedge clk) disable iff (rst)
    (cmp == ALL1) |=> !match_q);
  a_r1_increment: assert property (@(posedge clk) disable iff (rst)
    (step && cmp != ZERO && count != cmp && count != ALL1) |=> (count == $past(count) + 1'b1));
  a_r9_ovf_pulse: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q);
endmodule

// File: rtl/cc_capture.sv
module cc_capture #(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         pin,
  input  logic [1:0]   sel,
  input  logic [W-1:0] count,
  input  logic         clear_evt,
  output logic [W-1:0] cap_value,
  output logic         cap_irq,
  output logic         cap_spanned
);
  import cc_timer_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic                   prev_q;
  logic                   seen_q;
  logic                   cap_evt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign pin_s   = sync_q[SYNC_STAGES-1];
  assign cap_evt = tick && edge_hit(sel, pin_s, prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q      <= 1'b0;
      seen_q      <= 1'b0;
      cap_value   <= '0;
      cap_irq     <= 1'b0;
      cap_spanned <= 1'b0;
    end else begin
      cap_irq <= cap_evt;
      if (tick) prev_q <= pin_s;
      if (cap_evt) begin
        cap_value   <= count;
        cap_spanned <= seen_q;
        seen_q      <= clear_evt;
      end else if (clear_evt) begin
        seen_q <= 1'b1;
      end
    end
  end

  a_r6_capture_value: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cap_irq && cap_value == $past(count)));
  a_r8_span_set: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && seen_q) |=> cap_spanned);
  a_r8_span_clear: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !seen_q) |=> !cap_spanned);
  a_r5_none_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |=> !cap_irq);
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int unsigned W           = cc_timer_pkg::TMR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         run,
  input  logic         tick,
  input  logic         cap_in,
  output logic [W-1:0] count,
  output logic         match_irq,
  output logic         ovf_irq,
  output logic         cap_irq,
  output logic [W-1:0] cap_value,
  output logic         cap_spanned
);
  import cc_timer_pkg::*;

  logic [W-1:0] cmp_q;
  edge_sel_e    sel_q;
  logic         clear_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      sel_q <= EDGE_NONE;
    end else if (wr_en) begin
      if (wr_sel) sel_q <= edge_sel_e'(wr_data[1:0]);
      else        cmp_q <= wr_data;
    end
  end

  cc_count_core #(.W(W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .run       (run),
    .cmp       (cmp_q),
    .count     (count),
    .match_irq (match_irq),
    .ovf_irq   (ovf_irq),
    .clear_evt (clear_evt)
  );

  cc_capture #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .pin         (cap_in),
    .sel         (sel_q),
    .count       (count),
    .clear_evt   (clear_evt),
    .cap_value   (cap_value),
    .cap_irq     (cap_irq),
    .cap_spanned (cap_spanned)
  );

  a_r10_reset_defaults: assert property (@(posedge clk)
    rst |=> (cmp_q == '1 && sel_q == EDGE_NONE && count == '0));
endmodule

// File: tb/sim_cc_timer.sv
module sim_cc_timer;
  logic        clk = 1'b0;
  logic        rst, wr_en, wr_sel, run, tick, cap_in;
  logic [15:0] wr_data, count, cap_value;
  logic        match_irq, ovf_irq, cap_irq, cap_spanned;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10ns clk = ~clk;

  cc_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run(run), .tick(tick), .cap_in(cap_in), .count(count), .match_irq(match_irq),
    .ovf_irq(ovf_irq), .cap_irq(cap_irq), .cap_value(cap_value), .cap_spanned(cap_spanned)
  );

  typedef struct packed {
    logic [15:0] cmp;
    int          n;
    logic [15:0] cnt;
    int          nm;
    int          no;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{16'h0FFF, 4094,  16'h0FFE, 0, 0},
    '{16'h0FFF, 4095,  16'h0FFF, 0, 0},
    '{16'h0FFF, 4096,  16'h0000, 1, 0},
    '{16'h0005, 13,    16'h0001, 2, 0},
    '{16'h0001, 5,     16'h0001, 2, 0},
    '{16'h0010, 100,   16'h000F, 5, 0},
    '{16'hFFFF, 65537, 16'h0001, 0, 1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // R6 timing: third rising edge after the change carries the capture
  task automatic do_edge(input logic v, input bit expect_cap, input string tag);
    logic [15:0] seen, old;
    old = cap_value;
    cap_in = v;
    @(negedge clk);
    chk(cap_irq == 1'b0, {tag, " R6 early"}, cap_irq, 0);
    @(negedge clk);
    chk(cap_irq == 1'b0, {tag, " R6 early"}, cap_irq, 0);
    seen = count;
    @(negedge clk);
    if (expect_cap) begin
      chk(cap_irq == 1'b1, {tag, " cap_irq"}, cap_irq, 1);
      chk(cap_value == seen, {tag, " cap_value"}, cap_value, seen);
    end else begin
      chk(cap_irq == 1'b0, {tag, " ignored cap_irq"}, cap_irq, 0);
      chk(cap_value == old, {tag, " ignored cap_value"}, cap_value, old);
    end
    @(negedge clk);
    chk(cap_irq == 1'b0, "R9 cap pulse width", cap_irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    run = 1'b0; tick = 1'b0; cap_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(count == 0, "R10 count", count, 0);
    chk(cap_value == 0, "R10 cap_value", cap_value, 0);
    chk(cap_spanned == 0, "R10 cap_spanned", cap_spanned, 0);
    chk(!match_irq && !ovf_irq && !cap_irq, "R10 pulses", {match_irq, ovf_irq, cap_irq}, 0);

    // table: R1 stepping, R2 period clear, R4 free run
    foreach (VEC[i]) begin
      int nm, no;
      nm = 0; no = 0;
      run = 1'b0;
      wr(1'b0, VEC[i].cmp);
      run = 1'b1; tick = 1'b1;
      for (int k = 0; k < VEC[i].n; k++) begin
        @(negedge clk);
        if (match_irq) nm++;
        if (ovf_irq) no++;
      end
      tick = 1'b0;
      chk(count == VEC[i].cnt, "R1/R2/R4 count", count, VEC[i].cnt);
      chk(nm == VEC[i].nm, "R2/R4 match pulses", nm, VEC[i].nm);
      chk(no == VEC[i].no, "R4 overflow pulses", no, VEC[i].no);
    end

    // R1 tick low holds, run low zeroes
    begin
      logic [15:0] held;
      held = count;
      repeat (5) @(negedge clk);
      chk(count == held, "R1 hold without tick", count, held);
      run = 1'b0;
      @(negedge clk);
      chk(count == 0, "R1 run low zeroes", count, 0);
    end

    // R3 compare zero
    wr(1'b0, 16'h0000);
    run = 1'b1; tick = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(match_irq == 1'b1, "R3 match held", match_irq, 1);
      chk(count == 0, "R3 count frozen", count, 0);
    end

    // R10 reset restores compare FFFFH
    do_reset();
    repeat (3) @(negedge clk);
    chk(count == 3, "R10 compare default free run", count, 3);
    chk(match_irq == 1'b0, "R10 no match after reset", match_irq, 0);

    // R5 selection none, rising, falling; R7 both
    do_edge(1'b1, 1'b0, "R5 none rise");
    do_edge(1'b0, 1'b0, "R5 none fall");
    wr(1'b1, 16'h0001);
    do_edge(1'b1, 1'b1, "R6 rise sel");
    do_edge(1'b0, 1'b0, "R5 fall unselected");
    wr(1'b1, 16'h0002);
    do_edge(1'b1, 1'b0, "R5 rise unselected");
    do_edge(1'b0, 1'b1, "R5 fall sel");
    wr(1'b1, 16'h0003);
    do_edge(1'b1, 1'b1, "R7 both rise");
    do_edge(1'b0, 1'b1, "R7 both fall");

    // R8 span flag
    do_reset();
    wr(1'b0, 16'h0100);
    wr(1'b1, 16'h0003);
    do_edge(1'b1, 1'b1, "R8 first");
    chk(cap_spanned == 1'b0, "R8 no clear since reset", cap_spanned, 0);
    do_edge(1'b0, 1'b1, "R8 second");
    chk(cap_spanned == 1'b0, "R8 short interval", cap_spanned, 0);
    repeat (300) @(negedge clk);
    do_edge(1'b1, 1'b1, "R8 third");
    chk(cap_spanned == 1'b1, "R8 interval spans clear", cap_spanned, 1);
    do_edge(1'b0, 1'b1, "R8 fourth");
    chk(cap_spanned == 1'b0, "R8 flag drops", cap_spanned, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule